// File: doc/BRIEF.md
# Card Socket Command Strobe Sequencer

This block drives the command strobes for one 16-bit removable-card socket (PC Card or CompactFlash style). A request names an access space (common memory, attribute memory or I/O), a direction and a target socket. The block selects that space's 5-bit timing code, holds the right active-low strobe for a computed number of clocks, and honours the card's wait line. When it is finished it returns a one-cycle done pulse.

A two-bit configuration register tells the sequencer whether a card is present and whether the board has one socket or two. With no card present, the wait and 16-bit-width inputs are ignored. In one-socket boards the socket-select pin is reused as the active-low enable of the external data transceivers.

Timing for code C: the strobe is asserted first. For C clocks the wait line is not looked at. From then on, every clock of the hold phase needs a synchronized "not waiting" level. With no wait, the strobe stays low for 3C+5 clocks on a write and 3C+6 clocks on a read.

Top module: `card_cmd_seq`

## Requirements
- R1: After reset all four strobes and `attr_sel_n` are high, `done`, `busy` and `bus_16bit` are 0, `cfg_rdata` is 0, and `sock_sel` is 1 (one-socket mode, idle).
- R2: A write with code C and no wait holds exactly one strobe low for 3C+5 consecutive clocks. That strobe is `mem_wr_n` for space 0 (common) and space 1 (attribute), and `io_wr_n` for space 2 or 3 (I/O). `attr_sel_n` is low during the access only for space 1.
- R3: A read with code C and no wait holds `mem_rd_n` (spaces 0/1) or `io_rd_n` (spaces 2/3) low for exactly 3C+6 clocks.
- R4: The code used is `tcode_common`, `tcode_attr` or `tcode_io`, selected by the request's space.
- R5: With a card present, the strobe clock count stops while the two-flop-synchronized `card_wait_n` is low once C strobe clocks have passed. If `card_wait_n` rises during strobe clock j (j ≥ C, counting from 0), the strobe lasts 3C+5 (write) or 3C+6 (read) plus j+2−C clocks.
- R6: With no card present (`cfg_rdata[1]`=0), a low `card_wait_n` does not lengthen the strobe, and a low `card_io16_n` does not raise `bus_16bit`.
- R7: During a memory or attribute access `bus_16bit` is 1. During an I/O access with a card present, it equals the synchronized inverse of `card_io16_n`.
- R8: `done` is 0 in the first clock after the strobe rises, 1 in the clock after that, and 0 again one clock later, when `busy` is also 0.
- R9: A request raised while `busy` is 1 is ignored. The running access keeps its strobe and length, and no second access follows.
- R10: In two-socket mode (`cfg_rdata[0]`=1), `sock_sel` shows the socket of the last accepted request. In one-socket mode it is low exactly while a strobe is low.
- R11: A write with `cfg_we` stores `cfg_wdata[1]` as card-present and `cfg_wdata[0]` as two-socket mode. Both read back at the same positions on `cfg_rdata`.
- R12: The code extremes hold the formula: code 0 gives 5/6 clocks, code 29 gives 92/93, and code 31 gives 98/99 (write/read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 2 | Configuration write data: [1] card present, [0] two sockets |
| cfg_rdata | output | 2 | Configuration read data, same layout |
| tcode_common | input | CODE_W | Timing code for common memory |
| tcode_attr | input | CODE_W | Timing code for attribute memory |
| tcode_io | input | CODE_W | Timing code for I/O |
| req | input | 1 | Request, accepted when busy is 0 |
| req_space | input | 2 | 0 common, 1 attribute, 2/3 I/O |
| req_write | input | 1 | 1 write, 0 read |
| req_socket | input | 1 | Target socket in two-socket mode |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| card_wait_n | input | 1 | Card wait line, low means wait (asynchronous) |
| card_io16_n | input | 1 | Card 16-bit I/O indication, low means 16-bit (asynchronous) |
| mem_rd_n | output | 1 | Memory/attribute read strobe |
| mem_wr_n | output | 1 | Memory/attribute write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| attr_sel_n | output | 1 | Low during attribute-space accesses |
| bus_16bit | output | 1 | Access uses the 16-bit data width |
| sock_sel | output | 1 | Socket select, or transceiver enable in one-socket mode |

## Verification
Strobe lengths are measured for writes and reads in all three spaces, each with a different code. A length error then shows which term of the formula is wrong and whether the right code was selected. The wait line is released exactly at the end of the wait phase and also several clocks later. This separates a correct stall from an off-by-one in the synchronizer delay or in the wait-phase boundary. The same held-low wait and width inputs are repeated with the card marked absent, which shows whether masking happens. A stray request in mid-access and both socket modes round out the scenarios.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  // access space encoding on req_space; bit 1 set means I/O
  localparam logic [1:0] SP_COMMON = 2'd0;
  localparam logic [1:0] SP_ATTR   = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMD   = 2'd1,
    ST_RECOV = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

  function automatic logic space_is_io(input logic [1:0] sp);
    return sp[1];
  endfunction

endpackage

// File: rtl/card_sync2.sv
module card_sync2 #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/card_cfg_reg.sv
module card_cfg_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] wdata,
  output logic [1:0] rdata,
  output logic       card_present,
  output logic       two_sockets
);

  logic present_q, present_d;
  logic two_q, two_d;

  always_comb begin
    present_d = present_q;
    two_d     = two_q;
    if (we) begin
      present_d = wdata[1];
      two_d     = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= 1'b0;
      two_q     <= 1'b0;
    end else begin
      present_q <= present_d;
      two_q     <= two_d;
    end
  end

  assign rdata        = {present_q, two_q};
  assign card_present = present_q;
  assign two_sockets  = two_q;

endmodule

// File: rtl/card_cmd_timer.sv
module card_cmd_timer
  import card_seq_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  input  logic              is_read,
  input  logic              ready,
  output logic              active,
  output logic              busy,
  output logic              done
);

  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int CNT_W    = $clog2(3 * CODE_MAX + 7);

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  code_q;
  logic [CNT_W-1:0]  last_q;
  logic [CNT_W-1:0]  code_ext;
  logic [CNT_W-1:0]  last_calc;
  logic              load_en;
  logic              stall;

  assign code_ext  = {{(CNT_W-CODE_W){1'b0}}, code};
  // last strobe clock index: 3C+4 for write, 3C+5 for read
  assign last_calc = (code_ext << 1) + code_ext + CNT_W'(4) + CNT_W'(is_read);
  assign load_en   = (state_q == ST_IDLE) && start;
  assign stall     = (cnt_q >= code_q) && !ready;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_CMD;
          cnt_d   = '0;
        end
      end
      ST_CMD: begin
        if (!stall) begin
          if (cnt_q == last_q) state_d = ST_RECOV;
          else                 cnt_d   = cnt_q + 1'b1;
        end
      end
      ST_RECOV: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      last_q <= '0;
    end else if (load_en) begin
      code_q <= code_ext;
      last_q <= last_calc;
    end
  end

  assign active = (state_q == ST_CMD);
  assign busy   = (state_q != ST_IDLE);
  assign done   = (state_q == ST_DONE);

  // R5: once the wait phase is over, a not-ready cycle freezes the count
  assert_wait_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD && cnt_q >= code_q && !ready)
      |=> (state_q == ST_CMD && cnt_q == $past(cnt_q)));

  // R2: inside the wait phase the count always advances
  assert_wait_phase_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD && cnt_q < code_q)
      |=> (state_q == ST_CMD && cnt_q == $past(cnt_q) + 1'b1));

  // R8: the done pulse comes one clock after the strobe clears, and lasts one clock
  assert_done_after_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |=> done);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

endmodule

// File: rtl/card_cmd_seq.sv
module card_cmd_seq
  import card_seq_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_wdata,
  output logic [1:0]        cfg_rdata,
  input  logic [CODE_W-1:0] tcode_common,
  input  logic [CODE_W-1:0] tcode_attr,
  input  logic [CODE_W-1:0] tcode_io,
  input  logic              req,
  input  logic [1:0]        req_space,
  input  logic              req_write,
  input  logic              req_socket,
  output logic              busy,
  output logic              done,
  input  logic              card_wait_n,
  input  logic              card_io16_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic              attr_sel_n,
  output logic              bus_16bit,
  output logic              sock_sel
);

  logic              card_present;
  logic              two_sockets;
  logic [1:0]        pins_s;
  logic              wait_n_s;
  logic              io16_n_s;
  logic              start;
  logic              active;
  logic              ready;
  logic [CODE_W-1:0] code_sel;
  logic [1:0]        space_q;
  logic              wr_q;
  logic              sock_q;
  logic              is_io;

  card_cfg_reg u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (cfg_we),
    .wdata        (cfg_wdata),
    .rdata        (cfg_rdata),
    .card_present (card_present),
    .two_sockets  (two_sockets)
  );

  card_sync2 #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({card_io16_n, card_wait_n}),
    .q     (pins_s)
  );
  assign wait_n_s = pins_s[0];
  assign io16_n_s = pins_s[1];

  // absent card: wait and width lines are masked
  assign ready = !card_present || wait_n_s;

  always_comb begin
    case (req_space)
      SP_COMMON: code_sel = tcode_common;
      SP_ATTR:   code_sel = tcode_attr;
      default:   code_sel = tcode_io;
    endcase
  end

  assign start = req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      space_q <= SP_COMMON;
      wr_q    <= 1'b0;
      sock_q  <= 1'b0;
    end else if (start) begin
      space_q <= req_space;
      wr_q    <= req_write;
      sock_q  <= req_socket;
    end
  end

  card_cmd_timer #(.CODE_W(CODE_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .code    (code_sel),
    .is_read (!req_write),
    .ready   (ready),
    .active  (active),
    .busy    (busy),
    .done    (done)
  );

  assign is_io      = space_is_io(space_q);
  assign mem_rd_n   = !(active && !is_io && !wr_q);
  assign mem_wr_n   = !(active && !is_io &&  wr_q);
  assign io_rd_n    = !(active &&  is_io && !wr_q);
  assign io_wr_n    = !(active &&  is_io &&  wr_q);
  assign attr_sel_n = !(active && space_q == SP_ATTR);
  assign bus_16bit  = active && (!is_io || (card_present && !io16_n_s));
  assign sock_sel   = two_sockets ? sock_q : !active;

  // R2: at most one command strobe is low at a time
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!mem_rd_n, !mem_wr_n, !io_rd_n, !io_wr_n}));

  // R9: a request during an access leaves the latched access unchanged
  assert_busy_ignores_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> ($stable(space_q) && $stable(wr_q) && $stable(sock_q)));

  // R6: with no card the width line never widens an I/O access
  assert_absent_masks_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_present && !io_rd_n) |-> !bus_16bit);

endmodule

// File: tb/card_cmd_seq_tb.sv
`timescale 1ns/1ps
module card_cmd_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_wdata;
  logic [1:0] cfg_rdata;
  logic [4:0] tcode_common, tcode_attr, tcode_io;
  logic       req, req_write, req_socket;
  logic [1:0] req_space;
  logic       busy, done;
  logic       card_wait_n, card_io16_n;
  logic       mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, attr_sel_n, bus_16bit, sock_sel;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  card_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tcode_common(tcode_common), .tcode_attr(tcode_attr), .tcode_io(tcode_io),
    .req(req), .req_space(req_space), .req_write(req_write), .req_socket(req_socket),
    .busy(busy), .done(done), .card_wait_n(card_wait_n), .card_io16_n(card_io16_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .attr_sel_n(attr_sel_n), .bus_16bit(bus_16bit), .sock_sel(sock_sel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic target_strobe(input logic [1:0] sp, input logic wr);
    if (sp[1]) return wr ? io_wr_n : io_rd_n;
    return wr ? mem_wr_n : mem_rd_n;
  endfunction

  function automatic int lows();
    return int'(!mem_rd_n) + int'(!mem_wr_n) + int'(!io_rd_n) + int'(!io_wr_n);
  endfunction

  task automatic write_cfg(input logic present, input logic two);
    @(negedge clk);
    cfg_wdata = {present, two};
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // runs one access and measures it at negedges
  task automatic access(input logic [1:0] sp, input logic wr, input logic sk,
                        input int rel, input int inject,
                        output int len, output int stray, output logic attr_ok,
                        output logic wide_last, output logic sock_on,
                        output logic sock_off, output logic done_ok);
    int guard;
    @(negedge clk);
    req_space = sp; req_write = wr; req_socket = sk; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    len = 0; stray = 0; attr_ok = 1'b1; guard = 0;
    wide_last = 1'b0; sock_on = 1'b0;
    forever begin
      if (!target_strobe(sp, wr)) begin
        len++;
        if (len == 1) sock_on = sock_sel;
        wide_last = bus_16bit;
        if (attr_sel_n != (sp != 2'd1)) attr_ok = 1'b0;
        stray += lows() - 1;
        if (rel >= 0 && len == rel + 1) card_wait_n = 1'b1;
        if (inject >= 0 && len == inject + 1) begin
          req = 1'b1; req_space = 2'd2; req_write = ~wr; req_socket = ~sk;
        end else begin
          req = 1'b0;
        end
      end else if (len > 0) begin
        break;
      end else begin
        stray += lows();
      end
      guard++;
      if (guard > 500) break;
      @(negedge clk);
    end
    req = 1'b0;
    sock_off = sock_sel;
    done_ok = (done == 1'b0);
    @(negedge clk);
    done_ok = done_ok && (done == 1'b1);
    @(negedge clk);
    done_ok = done_ok && (done == 1'b0) && (busy == 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 strobes high", int'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, attr_sel_n}), 31);
    chk("R1 done/busy/wide", int'({done, busy, bus_16bit}), 0);
    chk("R1 cfg_rdata", int'(cfg_rdata), 0);
    chk("R1 sock_sel idle", int'(sock_sel), 1);
  endtask

  task automatic t_cfg();
    write_cfg(1'b1, 1'b0);
    chk("R11 present only", int'(cfg_rdata), 2);
    write_cfg(1'b0, 1'b1);
    chk("R11 two sockets only", int'(cfg_rdata), 1);
    write_cfg(1'b0, 1'b0);
    chk("R11 cleared", int'(cfg_rdata), 0);
  endtask

  task automatic t_spaces();
    int len, stray; logic a, w, so, sf, d;
    tcode_common = 5'd3; tcode_attr = 5'd7; tcode_io = 5'd10;
    access(2'd0, 1'b1, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R2 common write len", len, 14);
    chk("R2 common write attr", int'(a), 1);
    chk("R2 no other strobe", stray, 0);
    chk("R8 done timing", int'(d), 1);
    access(2'd0, 1'b0, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R3 common read len", len, 15);
    access(2'd1, 1'b1, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R4 attr write len", len, 26);
    chk("R2 attr select low", int'(a), 1);
    chk("R7 attr wide", int'(w), 1);
    access(2'd2, 1'b0, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R4 io read len", len, 36);
    chk("R3 io read only strobe", stray, 0);
    access(2'd3, 1'b1, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R4 io write len (space 3)", len, 35);
    chk("R8 done timing io", int'(d), 1);
  endtask

  task automatic t_extremes();
    int len, stray; logic a, w, so, sf, d;
    tcode_common = 5'd0; tcode_attr = 5'd29;
    access(2'd0, 1'b1, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R12 code0 write", len, 5);
    access(2'd0, 1'b0, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R12 code0 read", len, 6);
    access(2'd1, 1'b1, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R12 code29 write", len, 92);
    access(2'd1, 1'b0, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R12 code29 read", len, 93);
    tcode_common = 5'd31;
    access(2'd0, 1'b1, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R12 code31 write", len, 98);
    access(2'd0, 1'b0, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R12 code31 read", len, 99);
  endtask

  task automatic t_wait();
    int len, stray; logic a, w, so, sf, d;
    tcode_common = 5'd3;
    write_cfg(1'b1, 1'b0);
    card_wait_n = 1'b0;
    repeat (4) @(negedge clk);
    access(2'd0, 1'b1, 1'b0, 6, -1, len, stray, a, w, so, sf, d);
    chk("R5 wait released late", len, 19);
    card_wait_n = 1'b0;
    repeat (4) @(negedge clk);
    access(2'd0, 1'b1, 1'b0, 3, -1, len, stray, a, w, so, sf, d);
    chk("R5 wait released at phase end", len, 16);
    card_wait_n = 1'b1;
  endtask

  task automatic t_absent();
    int len, stray; logic a, w, so, sf, d;
    tcode_io = 5'd10;
    write_cfg(1'b0, 1'b0);
    card_wait_n = 1'b0; card_io16_n = 1'b0;
    repeat (4) @(negedge clk);
    access(2'd2, 1'b0, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R6 absent ignores wait", len, 36);
    chk("R6 absent ignores io16", int'(w), 0);
    card_wait_n = 1'b1; card_io16_n = 1'b1;
  endtask

  task automatic t_width();
    int len, stray; logic a, w, so, sf, d;
    tcode_io = 5'd2; tcode_common = 5'd2;
    write_cfg(1'b1, 1'b0);
    card_io16_n = 1'b0;
    repeat (4) @(negedge clk);
    access(2'd2, 1'b1, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R7 io 16-bit", int'(w), 1);
    card_io16_n = 1'b1;
    repeat (4) @(negedge clk);
    access(2'd2, 1'b1, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R7 io 8-bit", int'(w), 0);
    access(2'd0, 1'b1, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R7 memory always wide", int'(w), 1);
  endtask

  task automatic t_busy_req();
    int len, stray, extra; logic a, w, so, sf, d;
    tcode_common = 5'd3;
    access(2'd0, 1'b1, 1'b0, -1, 4, len, stray, a, w, so, sf, d);
    chk("R9 length unchanged", len, 14);
    chk("R9 no stray strobe", stray, 0);
    extra = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      extra += lows() + int'(busy);
    end
    chk("R9 no second access", extra, 0);
  endtask

  task automatic t_socket();
    int len, stray; logic a, w, so, sf, d;
    tcode_common = 5'd1;
    write_cfg(1'b1, 1'b0);
    access(2'd0, 1'b0, 1'b1, -1, -1, len, stray, a, w, so, sf, d);
    chk("R10 one-socket enable low", int'(so), 0);
    chk("R10 one-socket enable high after", int'(sf), 1);
    write_cfg(1'b1, 1'b1);
    access(2'd0, 1'b0, 1'b1, -1, -1, len, stray, a, w, so, sf, d);
    chk("R10 socket 1 during", int'(so), 1);
    chk("R10 socket 1 after", int'(sf), 1);
    access(2'd0, 1'b0, 1'b0, -1, -1, len, stray, a, w, so, sf, d);
    chk("R10 socket 0 during", int'(so), 0);
    write_cfg(1'b1, 1'b0);
  endtask

  initial begin
    #750000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 2'b00;
    tcode_common = '0; tcode_attr = '0; tcode_io = '0;
    req = 1'b0; req_space = 2'd0; req_write = 1'b0; req_socket = 1'b0;
    card_wait_n = 1'b1; card_io16_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_spaces();
    t_extremes();
    t_wait();
    t_absent();
    t_width();
    t_busy_req();
    t_socket();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule